// File: doc/BRIEF.md
# Noise-Shaping Clamp and Requantizer

This block takes one signed sample per oversampled tick and turns it into a short unsigned code for a pulse-width output stage. Each channel of an audio output path gets one instance, placed after the upsampler. First the sample is optionally limited to a programmable window. Then the word is cut down to a configurable number of bits, and the cut-off error is fed back into later samples. The feedback is first- or second-order error feedback, optionally with a one-LSB dither taken from a pseudo-random sequence. Finally a signed offset is added to the quantized value and the result is saturated into the output code range. This centres the code, so a zero input gives the middle of the pulse-width range.

With the width field set to 5 the quantizer keeps five magnitude bits and a sign. A window of +/-20479 and an offset of 20 then give codes spanning 0 to 39, which is a 40-level output. A bypass control turns off the feedback and the dither and leaves plain truncation. Dropping the enable clears the stored error history.

Top module: `nsq_requant`

## Requirements
- R1: After reset, out_valid is 0 and out_code is 0.
- R2: With cfg_clamp_en high, the sample is first raised to cfg_clamp_min if below it, then lowered to cfg_clamp_max if above it (signed compares). With cfg_clamp_en low, the sample passes unchanged.
- R3: The number of discarded bits is S = 15 - cfg_width for cfg_width 0..14, and S = 0 for cfg_width 15. The quantized value q is floor(v / 2^S), where v is the value presented to the quantizer.
- R4: out_code = q + cfg_bias (cfg_bias is a signed 16-bit value), saturated to the range 0..255.
- R5: With cfg_bypass high, v is the clamped sample with no feedback and no dither, and both stored errors are forced to 0.
- R6: With cfg_order2 low and no bypass, u = x - e1, where x is the clamped sample and e1 is the previous error. The new error is e = q*2^S - u, which then becomes e1, while the old e1 becomes e2.
- R7: With cfg_order2 high and no bypass, u = x - (2*e1 - e2). The errors update as in R6.
- R8: With cfg_dither_en high and no bypass, v = u + d, where d = +2^S or -2^S, chosen by a maximal-length 16-bit sequence that steps once per accepted sample. The error stays q*2^S - u. For a constant input over 2000 samples, the sum of q*2^S stays within 4*2^S of 2000*x.
- R9: out_valid is 1 in the cycle after a clock edge with enable and in_valid both high, and 0 after any other edge. out_code is updated on those same edges.
- R10: While enable is low, both stored errors are cleared and no sample is accepted. The first sample after re-enabling is quantized with zero feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low clears the error history |
| in_valid | input | 1 | Sample strobe, one per oversampled tick |
| in_sample | input | 16 | Signed input sample |
| cfg_bias | input | 16 | Signed offset added to the quantized value |
| cfg_clamp_max | input | 16 | Signed upper clamp limit |
| cfg_clamp_min | input | 16 | Signed lower clamp limit |
| cfg_width | input | 4 | Magnitude bits kept by the quantizer |
| cfg_clamp_en | input | 1 | Apply the clamp window |
| cfg_dither_en | input | 1 | Add one-LSB pseudo-random dither |
| cfg_order2 | input | 1 | 1 selects second-order shaping, 0 first-order |
| cfg_bypass | input | 1 | Plain truncation with no feedback or dither |
| out_valid | output | 1 | out_code holds a new value |
| out_code | output | 8 | Unsigned output code |

## Verification
A wrong stored error appears at out_code on the very next accepted sample, because the error is subtracted before truncation. A deterministic reference that replays the recurrence with dither off therefore catches it within one sample. A stale history after a disable shows up as an off-by-one code on the first sample after re-enabling. A broken dither or feedback loop shows up as a mean drift of more than a few LSBs over a long constant-input run. The bench measures that drift directly.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
   localparam int               SEQ_W    = 16;
   localparam logic [SEQ_W-1:0] SEQ_SEED = 16'hACE1;

   // taps 16,14,13,11: maximal-length feedback
   function automatic logic seq_feedback(input logic [SEQ_W-1:0] s);
      return s[15] ^ s[13] ^ s[12] ^ s[10];
   endfunction
endpackage

// File: rtl/nsq_clamp.sv
module nsq_clamp #(
   parameter int DATA_W = 16
) (
   input  logic                     en,
   input  logic signed [DATA_W-1:0] din,
   input  logic signed [DATA_W-1:0] lim_hi,
   input  logic signed [DATA_W-1:0] lim_lo,
   output logic signed [DATA_W-1:0] dout
);
   logic signed [DATA_W-1:0] raised;

   always_comb begin
      raised = (din < lim_lo) ? lim_lo : din;
      if (en) dout = (raised > lim_hi) ? lim_hi : raised;
      else    dout = din;
   end
endmodule

// File: rtl/nsq_lfsr.sv
module nsq_lfsr
   import nsq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic bit_out
);
   logic [SEQ_W-1:0] state;

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= SEQ_SEED;
      else if (step) state <= {state[SEQ_W-2:0], seq_feedback(state)};
   end

   assign bit_out = state[0];
endmodule

// File: rtl/nsq_shaper.sv
module nsq_shaper #(
   parameter int DATA_W = 16,
   parameter int OUT_W  = 8,
   parameter int SH_W   = 4,
   parameter int BIAS_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] x,
   input  logic [SH_W-1:0]          shift,
   input  logic                     order2,
   input  logic                     bypass,
   input  logic                     dither_on,
   input  logic                     dither_bit,
   input  logic signed [BIAS_W-1:0] bias,
   output logic                     out_valid,
   output logic [OUT_W-1:0]         out_code,
   output logic signed [DATA_W+1:0] err1,
   output logic signed [DATA_W+1:0] err2
);
   localparam int ERR_W = DATA_W + 2;
   localparam int SUM_W = DATA_W + 5;
   localparam logic signed [SUM_W-1:0] ONE      = SUM_W'(1);
   localparam logic signed [SUM_W-1:0] CODE_TOP = SUM_W'((2 ** OUT_W) - 1);
   localparam logic signed [SUM_W-1:0] ERR_HI   = SUM_W'((2 ** (ERR_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] ERR_LO   = -SUM_W'(2 ** (ERR_W - 1));

   logic signed [SUM_W-1:0] e1x, e2x, fb, u, step_sz, dv, qv, e_raw, code_sum;
   logic signed [ERR_W-1:0] e_sat;
   logic [OUT_W-1:0]        code_next;

   always_comb begin
      e1x     = SUM_W'(err1);
      e2x     = SUM_W'(err2);
      fb      = order2 ? ((e1x <<< 1) - e2x) : e1x;
      if (bypass) fb = '0;
      u       = SUM_W'(x) - fb;
      step_sz = ONE <<< shift;
      dv      = (dither_on && !bypass) ? (dither_bit ? step_sz : -step_sz) : '0;
      qv      = (u + dv) >>> shift;
      e_raw   = (qv <<< shift) - u;
      if (e_raw > ERR_HI)      e_sat = ERR_HI[ERR_W-1:0];
      else if (e_raw < ERR_LO) e_sat = ERR_LO[ERR_W-1:0];
      else                     e_sat = e_raw[ERR_W-1:0];
      code_sum = qv + SUM_W'(bias);
      if (code_sum < 0)             code_next = '0;
      else if (code_sum > CODE_TOP) code_next = CODE_TOP[OUT_W-1:0];
      else                          code_next = code_sum[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         err1      <= '0;
         err2      <= '0;
      end else if (!enable) begin
         out_valid <= 1'b0;
         err1      <= '0;
         err2      <= '0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         out_code  <= code_next;
         err1      <= bypass ? '0 : e_sat;
         err2      <= bypass ? '0 : err1;
      end else begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/nsq_requant.sv
module nsq_requant #(
   parameter int DATA_W     = 16,
   parameter int OUT_W      = 8,
   parameter int WIDTH_W    = 4,
   parameter int BIAS_W     = 16,
   parameter bit HAS_DITHER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic signed [BIAS_W-1:0] cfg_bias,
   input  logic signed [DATA_W-1:0] cfg_clamp_max,
   input  logic signed [DATA_W-1:0] cfg_clamp_min,
   input  logic [WIDTH_W-1:0]       cfg_width,
   input  logic                     cfg_clamp_en,
   input  logic                     cfg_dither_en,
   input  logic                     cfg_order2,
   input  logic                     cfg_bypass,
   output logic                     out_valid,
   output logic [OUT_W-1:0]         out_code
);
   localparam int SH_W = $clog2(DATA_W);
   localparam int TOPW = DATA_W - 1;

   if (DATA_W < 8 || DATA_W > 28) begin : g_bad_data_w
      $error("nsq_requant: DATA_W out of range");
   end
   if (OUT_W < 2 || OUT_W > DATA_W + 2) begin : g_bad_out_w
      $error("nsq_requant: OUT_W out of range");
   end
   if ((2 ** WIDTH_W) < DATA_W) begin : g_bad_width_w
      $error("nsq_requant: WIDTH_W too narrow for DATA_W");
   end

   logic signed [DATA_W-1:0] x_clamped;
   logic signed [DATA_W+1:0] err_q1, err_q2;
   logic [SH_W-1:0]          shift;
   logic                     dbit, dith_on;
   int                       wsel, shift_i;

   always_comb begin
      wsel    = int'(cfg_width);
      shift_i = (wsel >= TOPW) ? 0 : (TOPW - wsel);
      shift   = shift_i[SH_W-1:0];
   end

   nsq_clamp #(.DATA_W(DATA_W)) u_clamp (
      .en(cfg_clamp_en), .din(in_sample),
      .lim_hi(cfg_clamp_max), .lim_lo(cfg_clamp_min), .dout(x_clamped)
   );

   if (HAS_DITHER) begin : g_dither
      nsq_lfsr u_seq (
         .clk(clk), .rst_n(rst_n), .step(enable && in_valid), .bit_out(dbit)
      );
      assign dith_on = cfg_dither_en;
   end else begin : g_no_dither
      assign dbit    = 1'b0;
      assign dith_on = 1'b0;
   end

   nsq_shaper #(.DATA_W(DATA_W), .OUT_W(OUT_W), .SH_W(SH_W), .BIAS_W(BIAS_W)) u_shape (
      .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
      .x(x_clamped), .shift(shift), .order2(cfg_order2), .bypass(cfg_bypass),
      .dither_on(dith_on), .dither_bit(dbit), .bias(cfg_bias),
      .out_valid(out_valid), .out_code(out_code), .err1(err_q1), .err2(err_q2)
   );
endmodule

// File: rtl/nsq_requant_chk.sv
module nsq_requant_chk #(
   parameter int DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     enable,
   input logic                     in_valid,
   input logic                     cfg_clamp_en,
   input logic                     cfg_bypass,
   input logic signed [DATA_W-1:0] cfg_clamp_max,
   input logic signed [DATA_W-1:0] cfg_clamp_min,
   input logic signed [DATA_W-1:0] clamped,
   input logic signed [DATA_W+1:0] err1,
   input logic signed [DATA_W+1:0] err2,
   input logic                     out_valid
);
   p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_valid) |=> out_valid);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(enable && in_valid) |=> !out_valid);

   p_clamp_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clamp_en && cfg_clamp_min <= cfg_clamp_max)
         |-> (clamped >= cfg_clamp_min && clamped <= cfg_clamp_max));

   p_bypass_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_valid && cfg_bypass) |=> (err1 == 0 && err2 == 0));

   p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (err1 == 0 && err2 == 0));

   p_err_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err1 > -(2 ** DATA_W)) && (err1 <= (2 ** (DATA_W - 1))));
endmodule

bind nsq_requant nsq_requant_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
   .cfg_clamp_en(cfg_clamp_en), .cfg_bypass(cfg_bypass),
   .cfg_clamp_max(cfg_clamp_max), .cfg_clamp_min(cfg_clamp_min),
   .clamped(x_clamped), .err1(err_q1), .err2(err_q2), .out_valid(out_valid)
);

// File: tb/sim_nsq_requant.sv
`timescale 1ns/1ps
module sim_nsq_requant;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               enable = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_sample = '0;
   logic signed [15:0] cfg_bias = 16'sd20;
   logic signed [15:0] cfg_clamp_max = 16'sd20479;
   logic signed [15:0] cfg_clamp_min = -16'sd20479;
   logic [3:0]         cfg_width = 4'd5;
   logic               cfg_clamp_en = 1'b1;
   logic               cfg_dither_en = 1'b0;
   logic               cfg_order2 = 1'b0;
   logic               cfg_bypass = 1'b1;
   logic               out_valid;
   logic [7:0]         out_code;

   int     n_checks = 0;
   int     n_fail = 0;
   longint me1 = 0, me2 = 0;

   always #10 clk = ~clk;

   nsq_requant u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
      .in_sample(in_sample), .cfg_bias(cfg_bias), .cfg_clamp_max(cfg_clamp_max),
      .cfg_clamp_min(cfg_clamp_min), .cfg_width(cfg_width), .cfg_clamp_en(cfg_clamp_en),
      .cfg_dither_en(cfg_dither_en), .cfg_order2(cfg_order2), .cfg_bypass(cfg_bypass),
      .out_valid(out_valid), .out_code(out_code)
   );

   task automatic check(input bit ok, input string req, input longint got, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int shift_of(input int w);
      return (w >= 15) ? 0 : 15 - w;
   endfunction

   // reference built from R2..R7 (dither off)
   function automatic int model(input longint xin);
      longint x, fb, u, q, e, c;
      int     s;
      s = shift_of(int'(cfg_width));
      x = xin;
      if (cfg_clamp_en) begin
         if (x < longint'(cfg_clamp_min)) x = cfg_clamp_min;
         if (x > longint'(cfg_clamp_max)) x = cfg_clamp_max;
      end
      if (cfg_bypass) begin
         q = x >>> s;
         me1 = 0; me2 = 0;
      end else begin
         fb = cfg_order2 ? (2 * me1 - me2) : me1;
         u  = x - fb;
         q  = u >>> s;
         e  = (q <<< s) - u;
         me2 = me1; me1 = e;
      end
      c = q + longint'(cfg_bias);
      if (c < 0) c = 0;
      if (c > 255) c = 255;
      return int'(c);
   endfunction

   task automatic run_one(input logic signed [15:0] x, output int got);
      @(negedge clk);
      in_sample = x;
      in_valid  = 1'b1;
      @(posedge clk);
      #2;
      got = int'(out_code);
      in_valid = 1'b0;
   endtask

   task automatic expect_one(input logic signed [15:0] x, input string req);
      int got, exp;
      exp = model(longint'(x));
      run_one(x, got);
      check(got == exp, req, got, exp);
   endtask

   task automatic mean_run(input bit ord2, input string req);
      int     got;
      longint acc;
      acc = 0;
      @(negedge clk);
      enable = 1'b0;
      cfg_order2 = ord2;
      @(negedge clk);
      enable = 1'b1;
      for (int i = 0; i < 2000; i++) begin
         run_one(16'sd7777, got);
         acc += longint'(got - 20) * 1024;
      end
      acc -= 2000 * 7777;
      if (acc < 0) acc = -acc;
      check(acc <= 4 * 1024, req, acc, 4096);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int got, vary;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2;
      check(out_valid == 1'b0, "R1 valid", out_valid, 0);
      check(out_code == 8'd0, "R1 code", out_code, 0);
      @(negedge clk);
      rst_n = 1'b1;
      enable = 1'b1;

      // directed: typical setup, bypass
      run_one(16'sd32767, got);  check(got == 39, "R2 clamp high", got, 39);
      check(out_valid == 1'b1, "R9 valid after sample", out_valid, 1);
      @(posedge clk); #2;
      check(out_valid == 1'b0, "R9 idle", out_valid, 0);
      run_one(-16'sd32768, got); check(got == 0, "R2 clamp low", got, 0);
      run_one(16'sd0, got);      check(got == 20, "R4 bias centre", got, 20);
      cfg_clamp_en = 1'b0;
      run_one(16'sd32767, got);  check(got == 51, "R2 clamp off", got, 51);
      cfg_bias = 16'sd300;
      run_one(16'sd0, got);      check(got == 255, "R4 saturate high", got, 255);
      cfg_bias = -16'sd50;
      run_one(16'sd0, got);      check(got == 0, "R4 saturate low", got, 0);
      cfg_bias = 16'sd0; cfg_width = 4'd15;
      run_one(16'sd100, got);    check(got == 100, "R3 width 15", got, 100);
      cfg_bias = 16'sd5; cfg_width = 4'd0;
      run_one(-16'sd1, got);     check(got == 4, "R3 width 0", got, 4);

      // random bypass
      for (int i = 0; i < 200; i++) begin
         cfg_width     = 4'($urandom_range(15));
         cfg_bias      = 16'(int'($urandom_range(300)) - 100);
         cfg_clamp_en  = 1'($urandom);
         cfg_clamp_max = 16'(int'($urandom_range(20000)));
         cfg_clamp_min = -16'(int'($urandom_range(20000)));
         expect_one(16'($urandom), "R5 bypass");
      end

      // shaping, dither off
      cfg_width = 4'd5; cfg_bias = 16'sd20; cfg_clamp_en = 1'b1;
      cfg_clamp_max = 16'sd20479; cfg_clamp_min = -16'sd20479;
      cfg_bypass = 1'b0; cfg_order2 = 1'b0;
      for (int i = 0; i < 300; i++)
         expect_one(16'(int'($urandom_range(50000)) - 25000), "R6 first order");
      cfg_order2 = 1'b1;
      for (int i = 0; i < 300; i++)
         expect_one(16'(int'($urandom_range(50000)) - 25000), "R7 second order");
      for (int i = 0; i < 50; i++)
         expect_one(16'sd300, "R7 constant small");

      // disable clears history
      cfg_order2 = 1'b0;
      @(negedge clk); enable = 1'b0;
      @(negedge clk); enable = 1'b1; me1 = 0; me2 = 0;
      expect_one(16'sd500, "R6 step");
      expect_one(16'sd500, "R6 step");
      @(negedge clk); enable = 1'b0;
      @(posedge clk); #2;
      check(out_valid == 1'b0, "R10 no accept", out_valid, 0);
      @(negedge clk); enable = 1'b1; me1 = 0; me2 = 0;
      run_one(16'sd500, got);    check(got == 20, "R10 cleared history", got, 20);

      // dither
      cfg_dither_en = 1'b1; cfg_order2 = 1'b0;
      vary = 0;
      for (int i = 0; i < 200; i++) begin
         run_one(16'sd0, got);
         if (got != 20) vary++;
      end
      check(vary > 0, "R8 dither active", vary, 1);
      mean_run(1'b0, "R8 mean first order");
      mean_run(1'b1, "R8 mean second order");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule